// File: doc/BRIEF.md
# AES Byte-Serial Round Step Unit

This unit executes one custom instruction of a 32-bit RISC-V core that advances AES encryption by a single state byte. The instruction carries a round kind (ordinary or final) and a 2-bit lane selector `b`. The unit takes byte `b` of the second source operand and passes it through one 8-bit S-box. For an ordinary round it expands the substituted byte `s` into its mix-column contribution. For a final round the contribution is `s` alone. The contribution is turned into its lane position and XORed into the first source operand, which acts as the accumulator for one output column.

Software builds one output column by chaining four such steps. The accumulator starts at the round-key column. Step `r` takes the column that the row shift moves into row `r` and uses selector `b = r`. Sixteen steps yield a complete 128-bit round. Column words are little-endian: row 0 sits in bits [7:0].

The unit sits behind a valid/ready pair on each side and holds a one-entry output register. A step is accepted in the cycle where `in_valid && in_ready`. Its result is offered from the following cycle until `out_ready` is seen. `in_ready` is high when the output register is empty or is being drained in the same cycle. Back-pressure from the consumer therefore stalls the producer in that same cycle, and no work is lost.

Top module: `aes_bsr_unit`

## Requirements
- R1: An instruction is legal only when bits [6:0] equal 7'b0001011, bits [14:12] are 000, bits [31:30] are 00 and the round-kind field in bits [29:27] is 3'b000 (ordinary) or 3'b001 (final). Any other word is flagged illegal through `out_illegal`.
- R2: An illegal instruction produces `out_illegal = 1` and `out_result = 0`.
- R3: The substituted byte is the AES S-box image of bits [8b+7:8b] of `in_rs2`, where `b` is the selector in bits [26:25].
- R4: For an ordinary round, the unplaced contribution word, most significant byte first, is {3·s, s, s, 2·s}. The multiplication is in GF(2^8) modulo x^8+x^4+x^3+x+1.
- R5: For a final round, the unplaced contribution is `s` zero-extended to 32 bits. No mixing is applied.
- R6: Placement rotates the contribution right by 8·((4−b) mod 4) bits, so byte k of the contribution lands in lane (k+b) mod 4.
- R7: The result of a legal step is `in_rs1` XOR the placed contribution.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_result` and `out_illegal` hold their values.
- R9: A step accepted at a clock edge is presented with `out_valid` high right after that edge. If nothing new is accepted, `out_valid` drops after a cycle in which `out_ready` is high.
- R10: During and right after reset, `out_valid` is low and `in_ready` is high.
- R11: Sixteen chained steps, starting from the round-key columns, reproduce a full ordinary AES round. With the final kind, they reproduce the final round.
- R12: The register address fields (bits [24:20], [19:15], [11:7]) have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A step is offered |
| in_ready | output | 1 | The unit can take a step this cycle |
| in_insn | input | 32 | Instruction word |
| in_rs1 | input | WORD_W | Accumulator operand |
| in_rs2 | input | WORD_W | State column holding the selected byte |
| out_valid | output | 1 | A result is offered |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_result | output | WORD_W | Destination value |
| out_illegal | output | 1 | The offered result belongs to an illegal instruction |

## Verification
The bench builds the unit with its defaults: a 32-bit word and the custom-0 opcode value. With these defaults, all four lane selectors and both round kinds can be driven. This is enough to run the standard example round as sixteen chained steps, and the same chain with the final kind. Consumer back-pressure is switched on during the chains, so the stall-and-hold behaviour is exercised on real data. Each illegal field is then varied on its own, and steps that differ only in their register addresses are replayed.

// File: rtl/aes_bsr_pkg.sv
package aes_bsr_pkg;

  localparam logic [7:0] GF_RED = 8'h1b;
  localparam logic [7:0] AFF_C  = 8'h63;

  typedef enum logic [2:0] {
    KIND_MID  = 3'b000,
    KIND_LAST = 3'b001
  } kind_e;

  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? GF_RED : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_x2(sh);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

endpackage

// File: rtl/aes_bsr_decode.sv
module aes_bsr_decode #(
  parameter logic [6:0] OPCODE = 7'b0001011,
  parameter int         SEL_W  = 2
) (
  input  logic [31:0]      insn,
  output logic             legal,
  output logic             last,
  output logic [SEL_W-1:0] sel
);
  import aes_bsr_pkg::*;

  logic [2:0] kind;
  logic       fixed_ok;
  logic       kind_ok;

  always_comb begin
    kind     = insn[29:27];
    sel      = insn[25 +: SEL_W];
    fixed_ok = (insn[6:0] == OPCODE) && (insn[14:12] == 3'b000) && (insn[31:30] == 2'b00);
    kind_ok  = (kind == KIND_MID) || (kind == KIND_LAST);
    legal    = fixed_ok && kind_ok;
    last     = (kind == KIND_LAST);
  end
endmodule

// File: rtl/aes_bsr_sbox.sv
module aes_bsr_sbox (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  import aes_bsr_pkg::*;

  localparam int NSQ = 8;

  logic [7:0] pw  [NSQ];
  logic [7:0] acc [NSQ];
  logic [7:0] inv;

  // pw[i] = din^(2^i); the inverse is din^254 = product of pw[1..7]
  assign pw[0]  = din;
  assign acc[0] = 8'h01;

  generate
    for (genvar i = 1; i < NSQ; i++) begin : g_pow
      assign pw[i]  = gf_mul(pw[i-1], pw[i-1]);
      assign acc[i] = gf_mul(acc[i-1], pw[i]);
    end
  endgenerate

  always_comb begin
    inv  = acc[NSQ-1];
    dout = inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ AFF_C;
  end
endmodule

// File: rtl/aes_bsr_place.sv
module aes_bsr_place #(
  parameter int WORD_W = 32,
  localparam int NB    = WORD_W / 8,
  localparam int SEL_W = $clog2(NB)
) (
  input  logic [7:0]        sub,
  input  logic              last,
  input  logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] placed
);
  import aes_bsr_pkg::*;

  logic [7:0] lane_src [NB];
  logic [7:0] s2;
  logic [7:0] s3;

  always_comb begin
    s2 = gf_x2(sub);
    s3 = s2 ^ sub;
  end

  // unplaced word, lane 0 least significant: {3s, s, s, 2s}
  generate
    for (genvar k = 0; k < NB; k++) begin : g_lane
      if (k == 0) begin : g_l0
        assign lane_src[k] = last ? sub : s2;
      end else if (k == NB - 1) begin : g_ltop
        assign lane_src[k] = last ? 8'h00 : s3;
      end else begin : g_lmid
        assign lane_src[k] = last ? 8'h00 : sub;
      end
    end
  endgenerate

  // lane j receives source lane (j - sel) mod NB
  always_comb begin
    for (int j = 0; j < NB; j++) begin
      logic [SEL_W-1:0] idx;
      idx = SEL_W'(j) - sel;
      placed[8*j +: 8] = lane_src[idx];
    end
  end
endmodule

// File: rtl/aes_bsr_unit.sv
module aes_bsr_unit #(
  parameter int         WORD_W = 32,
  parameter logic [6:0] OPCODE = 7'b0001011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_insn,
  input  logic [WORD_W-1:0] in_rs1,
  input  logic [WORD_W-1:0] in_rs2,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_result,
  output logic              out_illegal
);
  localparam int NB    = WORD_W / 8;
  localparam int SEL_W = $clog2(NB);

  logic              dec_legal;
  logic              dec_last;
  logic [SEL_W-1:0]  dec_sel;
  logic [7:0]        pick;
  logic [7:0]        sub;
  logic [WORD_W-1:0] placed;
  logic [WORD_W-1:0] res_d;
  logic              take;

  aes_bsr_decode #(.OPCODE(OPCODE), .SEL_W(SEL_W)) u_dec (
    .insn  (in_insn),
    .legal (dec_legal),
    .last  (dec_last),
    .sel   (dec_sel)
  );

  always_comb pick = in_rs2[8*dec_sel +: 8];

  aes_bsr_sbox u_sbox (
    .din  (pick),
    .dout (sub)
  );

  aes_bsr_place #(.WORD_W(WORD_W)) u_place (
    .sub    (sub),
    .last   (dec_last),
    .sel    (dec_sel),
    .placed (placed)
  );

  always_comb begin
    res_d    = dec_legal ? (in_rs1 ^ placed) : '0;
    in_ready = !out_valid || out_ready;
    take     = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_result  <= res_d;
      out_illegal <= !dec_legal;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/aes_bsr_unit_chk.sv
module aes_bsr_unit_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_result,
  input logic              out_illegal
);
  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

  p_stall_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  p_illegal_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_result == '0));

  p_empty_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind aes_bsr_unit aes_bsr_unit_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_illegal (out_illegal)
);

// File: tb/aes_bsr_unit_tb_top.sv
module aes_bsr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic [31:0] in_rs1 = '0;
  logic [31:0] in_rs2 = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_illegal;

  int n_chk = 0;
  int n_bad = 0;
  bit bp_on = 1'b0;

  logic [31:0] q_res [$];
  logic        q_ill [$];
  string       q_tag [$];

  logic [7:0] sb [256];

  always #2 clk = ~clk;

  aes_bsr_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn),
    .in_rs1(in_rs1), .in_rs2(in_rs2),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_illegal(out_illegal)
  );

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] rl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic build_sbox();
    logic [7:0] p, q;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ rl8(q, 1) ^ rl8(q, 2) ^ rl8(q, 3) ^ rl8(q, 4) ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  // expected single step from R3..R7
  function automatic logic [31:0] step_ref(input logic [31:0] acc, input logic [31:0] col,
                                           input bit fin, input int b);
    logic [7:0]  s;
    logic [31:0] w;
    s = sb[col[8*b +: 8]];
    w = fin ? {24'h0, s} : {xt(s) ^ s, s, s, xt(s)};
    for (int k = 0; k < b; k++) w = {w[23:0], w[31:24]};
    return acc ^ w;
  endfunction

  function automatic logic [31:0] mk_insn(input logic [2:0] kind, input logic [1:0] b,
                                          input logic [4:0] r2, input logic [4:0] r1,
                                          input logic [4:0] rd);
    return {2'b00, kind, b, r2, r1, 3'b000, rd, 7'b0001011};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] insn, input logic [31:0] a, input logic [31:0] c,
                      input logic [31:0] exp, input logic ill, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_insn = insn; in_rs1 = a; in_rs2 = c;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    q_res.push_back(exp); q_ill.push_back(ill); q_tag.push_back(tag);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    int cyc;
    bit stall_prev;
    logic [31:0] res_prev;
    logic ill_prev;
    cyc = 0; stall_prev = 0; res_prev = '0; ill_prev = 0;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (stall_prev) begin
        check(out_valid && out_result == res_prev && out_illegal == ill_prev,
              "R8 hold under stall", out_result, res_prev);
      end
      if (out_valid && out_ready) begin
        if (q_res.size() == 0) begin
          check(1'b0, "R9 unexpected result", out_result, 32'h0);
        end else begin
          logic [31:0] e;
          logic ei;
          string t;
          e = q_res.pop_front(); ei = q_ill.pop_front(); t = q_tag.pop_front();
          check(out_result == e && out_illegal == ei, t, out_result, e);
        end
      end
      stall_prev = out_valid && !out_ready;
      res_prev = out_result;
      ill_prev = out_illegal;
    end
  end

  localparam logic [127:0] ST_IN  = 128'h193de3bea0f4e22b9ac68d2ae9f84808;
  localparam logic [127:0] RKEY   = 128'ha0fafe1788542cb123a339392a6c7605;
  localparam logic [127:0] ST_OUT = 128'ha49c7ff2689f352b6b5bea43026a5049;

  function automatic logic [7:0] byt(input logic [127:0] v, input int i);
    return v[127-8*i -: 8];
  endfunction

  function automatic logic [31:0] colw(input logic [127:0] v, input int c);
    return {byt(v, 4*c+3), byt(v, 4*c+2), byt(v, 4*c+1), byt(v, 4*c)};
  endfunction

  // software round model: SubBytes, ShiftRows, optional MixColumns, AddRoundKey
  function automatic logic [127:0] round_ref(input logic [127:0] st, input logic [127:0] rk,
                                             input bit fin);
    logic [7:0] t [16];
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        t[4*c+r] = sb[byt(st, 4*((c+r)%4)+r)];
    for (int c = 0; c < 4; c++) begin
      logic [7:0] a0, a1, a2, a3;
      a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
      if (!fin) begin
        t[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
        t[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
        t[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
        t[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
      end
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = t[i] ^ byt(rk, i);
    return o;
  endfunction

  task automatic run_chain(input bit fin);
    logic [127:0] ref_o;
    ref_o = round_ref(ST_IN, RKEY, fin);
    for (int c = 0; c < 4; c++) begin
      logic [31:0] acc;
      acc = colw(RKEY, c);
      for (int r = 0; r < 4; r++) begin
        logic [31:0] src, nxt;
        src = colw(ST_IN, (c + r) % 4);
        nxt = step_ref(acc, src, fin, r);
        if (r == 3)
          send(mk_insn(fin ? 3'b001 : 3'b000, 2'(r), 5'd2, 5'd5, 5'd5), acc, src,
               colw(ref_o, c), 1'b0, fin ? "R11 R5 final-round column" : "R11 R4 round column");
        else
          send(mk_insn(fin ? 3'b001 : 3'b000, 2'(r), 5'd2, 5'd5, 5'd5), acc, src,
               nxt, 1'b0, fin ? "R5 R6 final step" : "R4 R6 R7 step");
        acc = nxt;
      end
    end
  endtask

  initial begin
    build_sbox();
    fork
      begin
        logic [31:0] base;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(!out_valid && in_ready, "R10 reset state", {30'h0, out_valid, in_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(!out_valid && in_ready, "R10 after reset", {30'h0, out_valid, in_ready}, 32'h1);

        // bench model sanity against the published example round
        check(round_ref(ST_IN, RKEY, 1'b0) == ST_OUT, "R11 reference round",
              round_ref(ST_IN, RKEY, 1'b0) >> 96, ST_OUT >> 96);

        // R9 latency, no back-pressure
        send(mk_insn(3'b000, 2'd0, 5'd1, 5'd1, 5'd1), 32'h0, 32'h0000_0053,
             step_ref(32'h0, 32'h0000_0053, 1'b0, 0), 1'b0, "R3 R4 single step");
        idle();
        #1;
        check(out_valid, "R9 valid after accept", {31'h0, out_valid}, 32'h1);
        @(negedge clk); #1;
        check(!out_valid, "R9 drained", {31'h0, out_valid}, 32'h0);

        // R3/R6 lane selection and placement, each selector
        for (int b = 0; b < 4; b++) begin
          send(mk_insn(3'b001, 2'(b), 5'd3, 5'd4, 5'd6), 32'h0, 32'h53ca_0100,
               {24'h0, sb[8'(32'h53ca_0100 >> (8*b))]} << (8*b), 1'b0, "R3 R6 final lane");
          send(mk_insn(3'b000, 2'(b), 5'd3, 5'd4, 5'd6), 32'h0f0f_f0f0, 32'h53ca_0100,
               step_ref(32'h0f0f_f0f0, 32'h53ca_0100, 1'b0, b), 1'b0, "R4 R6 R7 mix lane");
        end
        idle();

        // R11 full rounds with back-pressure
        bp_on = 1'b1;
        run_chain(1'b0);
        run_chain(1'b1);
        idle();
        bp_on = 1'b0;

        // R1/R2 illegal encodings
        base = mk_insn(3'b000, 2'd1, 5'd2, 5'd3, 5'd4);
        send(base ^ 32'h0000_0001, 32'hdead_beef, 32'h1234_5678, 32'h0, 1'b1, "R1 R2 bad opcode");
        send(base | 32'h0000_1000, 32'hdead_beef, 32'h1234_5678, 32'h0, 1'b1, "R1 R2 bad minor bits");
        send(base | 32'h8000_0000, 32'hdead_beef, 32'h1234_5678, 32'h0, 1'b1, "R1 R2 bad top bits");
        for (int k = 2; k < 8; k++)
          send(mk_insn(3'(k), 2'd1, 5'd2, 5'd3, 5'd4), 32'hdead_beef, 32'h1234_5678,
               32'h0, 1'b1, "R1 R2 bad round kind");
        send(base, 32'hdead_beef, 32'h1234_5678,
             step_ref(32'hdead_beef, 32'h1234_5678, 1'b0, 1), 1'b0, "R1 legal after illegal");

        // R12 register address fields ignored
        send(mk_insn(3'b000, 2'd2, 5'd0, 5'd0, 5'd0), 32'h0123_4567, 32'h89ab_cdef,
             step_ref(32'h0123_4567, 32'h89ab_cdef, 1'b0, 2), 1'b0, "R12 addr zeros");
        send(mk_insn(3'b000, 2'd2, 5'd31, 5'd17, 5'd9), 32'h0123_4567, 32'h89ab_cdef,
             step_ref(32'h0123_4567, 32'h89ab_cdef, 1'b0, 2), 1'b0, "R12 addr mixed");
        idle();
        repeat (4) @(negedge clk);
        check(q_res.size() == 0, "R9 all results delivered", q_res.size(), 32'h0);
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R9 watchdog expired", 32'h0, 32'h1);
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule